// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional direct branch will be taken. Decode presents the branch's PC and the sign of its displacement, and the predictor answers in the same cycle, so a new branch may be looked up on every cycle, including several in a row. The answer is a taken/not-taken bit plus a snapshot of the global outcome history used to form it. The pipeline carries that snapshot alongside the branch. Two stages later, when the branch resolves, the pipeline hands back the PC, the snapshot and the real outcome. A correct guess costs nothing, and a wrong one costs a two-cycle redirect in the fetch unit.

A build-time parameter picks one of six schemes:
- static: backward taken, forward not taken;
- bimodal: a PC-indexed counter table;
- global: a table indexed by history alone;
- gshare: PC bits XOR history;
- gselect: PC bits joined to history bits;
- combined: a bimodal table and a gshare table, with a per-PC chooser table deciding which of the two to follow.

Every table holds 2-bit saturating counters. No table has more than 256 entries.

Top module: `tourney_bp`

## Requirements
- R1: After reset every counter table predicts not-taken for any PC, the chooser favours the bimodal side, and `lk_hist` reads zero.
- R2: The static scheme predicts `lk_taken` = `lk_backward`, and resolved updates never change that answer.
- R3: Each counter is 2 bits and saturates at 0 and 3, starting at 1. A taken update adds one and a not-taken update subtracts one. The prediction is bit 1 of the counter, so a strongly taken entry survives one not-taken outcome.
- R4: The bimodal index is PC bits [9:2]. Two PCs that differ only above bit 9 share an entry, and PCs that differ in bits [9:2] do not.
- R5: Each update shifts `up_taken` into bit 0 of the 8-bit global history, and the oldest bit is dropped. With no update, `lk_hist` holds its value.
- R6: The global scheme indexes its table with the history alone, so any PC looked up under a trained history gets the trained prediction.
- R7: The gshare scheme indexes with PC bits [9:2] XOR the history.
- R8: The gselect scheme indexes with {PC bits [5:2], history bits [3:0]}. PC bits above bit 5 do not take part.
- R9: Updates write the entry chosen by `up_pc` and the returned `up_hist`, not by the current history. Tables change only on an update.
- R10: A lookup in the same cycle as an update sees the table contents from before that update. The update is visible to the next cycle's lookup, and lookups on consecutive cycles are each answered correctly.
- R11: In the combined scheme, the chooser counter indexed by PC bits [9:2] selects the gshare side when its bit 1 is set, and the bimodal side otherwise.
- R12: The chooser counter moves only when the two sides disagree at update time, stepping toward the side that matched the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | PC of the branch in decode |
| lk_backward | input | 1 | Displacement sign of that branch (1 = backward) |
| lk_taken | output | 1 | Predicted direction, combinational from the lookup inputs |
| lk_hist | output | 8 | Global history used by this lookup, carried along by the pipeline |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_hist | input | 8 | History snapshot returned with the resolved branch |
| up_taken | input | 1 | Resolved direction |

## Verification
The assertions assume that `up_valid` marks exactly the cycles in which an outcome is reported. They also assume that `lk_pc` and `lk_backward` change only when decode moves on, so a frozen prediction with no update in between is a real property of the tables. The bench follows these rules: it drives every input on the falling edge, and it raises `up_valid` for one cycle per resolved branch. It always returns, as `up_hist`, either the history it chose for training or the snapshot it read earlier from `lk_hist`.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [2:0] {
        SCH_STATIC,
        SCH_BIMODAL,
        SCH_GLOBAL,
        SCH_GSHARE,
        SCH_GSELECT,
        SCH_COMBINED
    } bp_scheme_e;

    localparam int MAX_IDX_W = 8;

    typedef logic [1:0] ctr2_t;

    // direction tables: weakly not-taken; chooser: weakly prefers bimodal
    localparam ctr2_t CTR_WEAK_LO = 2'b01;

    function automatic ctr2_t ctr_step(ctr2_t c, logic up);
        if (up) begin
            return (c == 2'b11) ? c : c + 2'd1;
        end
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

endpackage

// File: rtl/bp_index_gen.sv
module bp_index_gen
    import bp_pkg::*;
#(
    parameter bp_scheme_e SCHEME   = SCH_BIMODAL,
    parameter int         PC_W     = 32,
    parameter int         IDX_W    = 8,
    parameter int         SEL_PC_W = 4
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);

    localparam int SEL_H_W = IDX_W - SEL_PC_W;

    generate
        if (SCHEME == SCH_GLOBAL) begin : g_hist_only
            assign idx = hist;
        end else if (SCHEME == SCH_GSHARE || SCHEME == SCH_COMBINED) begin : g_xor
            assign idx = pc[IDX_W+1:2] ^ hist;
        end else if (SCHEME == SCH_GSELECT) begin : g_concat
            assign idx = {pc[SEL_PC_W+1:2], hist[SEL_H_W-1:0]};
        end else begin : g_pc_only
            assign idx = pc[IDX_W+1:2];
        end
    endgenerate

    logic idx_unused;
    assign idx_unused = ^{pc, hist};

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int    IDX_W   = 8,
    parameter ctr2_t RST_VAL = CTR_WEAK_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic [IDX_W-1:0] chk_idx,
    output ctr2_t            chk_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        ctr2_t [DEPTH-1:0] ctr;
    } tbl_state_t;

    tbl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.ctr[wr_idx] = ctr_step(s_q.ctr[wr_idx], wr_up);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= {DEPTH{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ctr  = s_q.ctr[rd_idx];
    assign chk_ctr = s_q.ctr[chk_idx];

    AST_CTR_LEAVES_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up) |=> (s_q.ctr[$past(wr_idx)] != 2'b00));   // R3
    AST_CTR_LEAVES_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up) |=> (s_q.ctr[$past(wr_idx)] != 2'b11));  // R3
    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q));                                  // R9

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
    import bp_pkg::*;
#(
    parameter bp_scheme_e SCHEME      = SCH_COMBINED,
    parameter int         PC_W        = 32,
    parameter int         BIM_BITS    = 8,
    parameter int         GLB_BITS    = 8,
    parameter int         SEL_PC_BITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PC_W-1:0]       lk_pc,
    input  logic                  lk_backward,
    output logic                  lk_taken,
    output logic [((GLB_BITS > MAX_IDX_W) ? MAX_IDX_W : GLB_BITS)-1:0] lk_hist,
    input  logic                  up_valid,
    input  logic [PC_W-1:0]       up_pc,
    input  logic [((GLB_BITS > MAX_IDX_W) ? MAX_IDX_W : GLB_BITS)-1:0] up_hist,
    input  logic                  up_taken
);

    localparam int  BIM_W    = (BIM_BITS > MAX_IDX_W) ? MAX_IDX_W : BIM_BITS;
    localparam int  GLB_W    = (GLB_BITS > MAX_IDX_W) ? MAX_IDX_W : GLB_BITS;
    localparam int  HIST_W   = GLB_W;
    localparam int  SEL_W    = (SEL_PC_BITS >= GLB_W) ? GLB_W - 1 : SEL_PC_BITS;
    localparam bit  USE_BIM  = (SCHEME == SCH_BIMODAL) || (SCHEME == SCH_COMBINED);
    localparam bit  USE_GLB  = (SCHEME == SCH_GLOBAL) || (SCHEME == SCH_GSHARE) ||
                               (SCHEME == SCH_GSELECT) || (SCHEME == SCH_COMBINED);
    localparam bit  USE_META = (SCHEME == SCH_COMBINED);

    typedef struct packed {
        logic [HIST_W-1:0] ghr;
    } top_state_t;

    top_state_t s_d, s_q;

    ctr2_t bim_lk_ctr, bim_up_ctr;
    ctr2_t glb_lk_ctr, glb_up_ctr;
    ctr2_t meta_lk_ctr, meta_up_ctr;
    logic  sides_differ;
    logic  glb_was_right;

    // ---------------- history register ----------------
    always_comb begin
        s_d = s_q;
        if (up_valid) begin
            s_d.ghr = {s_q.ghr[HIST_W-2:0], up_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lk_hist = s_q.ghr;

    // ---------------- bimodal side (also chooser index) ----------------
    logic [BIM_W-1:0] bim_lk_idx, bim_up_idx;

    bp_index_gen #(.SCHEME(SCH_BIMODAL), .PC_W(PC_W), .IDX_W(BIM_W), .SEL_PC_W(1))
        u_bim_lk_idx (.pc(lk_pc), .hist('0), .idx(bim_lk_idx));
    bp_index_gen #(.SCHEME(SCH_BIMODAL), .PC_W(PC_W), .IDX_W(BIM_W), .SEL_PC_W(1))
        u_bim_up_idx (.pc(up_pc), .hist('0), .idx(bim_up_idx));

    generate
        if (USE_BIM) begin : g_bim
            bp_ctr_table #(.IDX_W(BIM_W), .RST_VAL(CTR_WEAK_LO)) u_bim_tbl (
                .clk(clk), .rst_n(rst_n),
                .rd_idx(bim_lk_idx), .rd_ctr(bim_lk_ctr),
                .chk_idx(bim_up_idx), .chk_ctr(bim_up_ctr),
                .wr_en(up_valid), .wr_idx(bim_up_idx), .wr_up(up_taken)
            );
        end else begin : g_no_bim
            assign bim_lk_ctr = CTR_WEAK_LO;
            assign bim_up_ctr = CTR_WEAK_LO;
        end
    endgenerate

    // ---------------- global side ----------------
    generate
        if (USE_GLB) begin : g_glb
            logic [GLB_W-1:0] glb_lk_idx, glb_up_idx;

            bp_index_gen #(.SCHEME(SCHEME), .PC_W(PC_W), .IDX_W(GLB_W), .SEL_PC_W(SEL_W))
                u_glb_lk_idx (.pc(lk_pc), .hist(s_q.ghr), .idx(glb_lk_idx));
            bp_index_gen #(.SCHEME(SCHEME), .PC_W(PC_W), .IDX_W(GLB_W), .SEL_PC_W(SEL_W))
                u_glb_up_idx (.pc(up_pc), .hist(up_hist), .idx(glb_up_idx));

            bp_ctr_table #(.IDX_W(GLB_W), .RST_VAL(CTR_WEAK_LO)) u_glb_tbl (
                .clk(clk), .rst_n(rst_n),
                .rd_idx(glb_lk_idx), .rd_ctr(glb_lk_ctr),
                .chk_idx(glb_up_idx), .chk_ctr(glb_up_ctr),
                .wr_en(up_valid), .wr_idx(glb_up_idx), .wr_up(up_taken)
            );
        end else begin : g_no_glb
            assign glb_lk_ctr = CTR_WEAK_LO;
            assign glb_up_ctr = CTR_WEAK_LO;
        end
    endgenerate

    // ---------------- chooser ----------------
    assign sides_differ  = bim_up_ctr[1] ^ glb_up_ctr[1];
    assign glb_was_right = (glb_up_ctr[1] == up_taken);

    generate
        if (USE_META) begin : g_meta
            bp_ctr_table #(.IDX_W(BIM_W), .RST_VAL(CTR_WEAK_LO)) u_meta_tbl (
                .clk(clk), .rst_n(rst_n),
                .rd_idx(bim_lk_idx), .rd_ctr(meta_lk_ctr),
                .chk_idx(bim_up_idx), .chk_ctr(meta_up_ctr),
                .wr_en(up_valid && sides_differ), .wr_idx(bim_up_idx),
                .wr_up(glb_was_right)
            );

            AST_META_FOLLOWS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                (up_valid && sides_differ && glb_was_right && meta_up_ctr == 2'b01)
                |=> (meta_lk_ctr[1] || $past(bim_lk_idx) != $past(bim_up_idx)
                     || !$stable(lk_pc)));                                   // R12
        end else begin : g_no_meta
            assign meta_lk_ctr = CTR_WEAK_LO;
            assign meta_up_ctr = CTR_WEAK_LO;
        end
    endgenerate

    // ---------------- prediction select ----------------
    always_comb begin
        case (SCHEME)
            SCH_STATIC:   lk_taken = lk_backward;
            SCH_BIMODAL:  lk_taken = bim_lk_ctr[1];
            SCH_COMBINED: lk_taken = meta_lk_ctr[1] ? glb_lk_ctr[1] : bim_lk_ctr[1];
            default:      lk_taken = glb_lk_ctr[1];
        endcase
    end

    logic in_unused;
    assign in_unused = ^{lk_pc, up_pc, up_hist, lk_backward, bim_lk_ctr, bim_up_ctr,
                         glb_lk_ctr, glb_up_ctr, meta_lk_ctr, meta_up_ctr};

    AST_HIST_TAKES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (lk_hist[0] == $past(up_taken)));                    // R5
    AST_HIST_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));                                  // R5
    AST_PRED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> (!($stable(lk_pc) && $stable(lk_backward)) || $stable(lk_taken)));  // R9

endmodule

// File: tb/tourney_bp_bench.sv
module tourney_bp_bench;
    import bp_pkg::*;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_backward = 1'b0;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [7:0]  up_hist = '0;
    logic        up_taken = 1'b0;

    logic tk_cb, tk_st, tk_bi, tk_gl, tk_gs, tk_gx;
    logic [7:0] h_cb, h_st, h_bi, h_gl, h_gs, h_gx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tourney_bp #(.SCHEME(SCH_COMBINED)) u_tourney_bp (.clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_backward(lk_backward), .lk_taken(tk_cb), .lk_hist(h_cb),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));
    tourney_bp #(.SCHEME(SCH_STATIC)) u_tourney_bp_st (.clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_backward(lk_backward), .lk_taken(tk_st), .lk_hist(h_st),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));
    tourney_bp #(.SCHEME(SCH_BIMODAL)) u_tourney_bp_bi (.clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_backward(lk_backward), .lk_taken(tk_bi), .lk_hist(h_bi),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));
    tourney_bp #(.SCHEME(SCH_GLOBAL)) u_tourney_bp_gl (.clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_backward(lk_backward), .lk_taken(tk_gl), .lk_hist(h_gl),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));
    tourney_bp #(.SCHEME(SCH_GSHARE)) u_tourney_bp_gs (.clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_backward(lk_backward), .lk_taken(tk_gs), .lk_hist(h_gs),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));
    tourney_bp #(.SCHEME(SCH_GSELECT)) u_tourney_bp_gx (.clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_backward(lk_backward), .lk_taken(tk_gx), .lk_hist(h_gx),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; up_valid = 1'b0; lk_backward = 1'b0; lk_pc = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic upd(input logic [31:0] pc, input logic [7:0] hist, input logic tk);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_hist = hist; up_taken = tk;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc, input logic bk);
        lk_pc = pc; lk_backward = bk;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        look(32'h100, 1'b0);
        chk("R1 combined not-taken", tk_cb, 0);
        chk("R1 bimodal not-taken", tk_bi, 0);
        chk("R1 global not-taken", tk_gl, 0);
        chk("R1 gshare not-taken", tk_gs, 0);
        chk("R1 gselect not-taken", tk_gx, 0);
        chk("R1 history zero", h_cb, 0);
    endtask

    task automatic t_static();
        do_reset();
        look(32'h80, 1'b1);
        chk("R2 backward taken", tk_st, 1);
        look(32'h80, 1'b0);
        chk("R2 forward not-taken", tk_st, 0);
        for (int i = 0; i < 3; i++) upd(32'h80, 8'h0, 1'b1);
        look(32'h80, 1'b0);
        chk("R2 updates ignored", tk_st, 0);
        look(32'h80, 1'b1);
        chk("R2 backward after updates", tk_st, 1);
        lk_backward = 1'b0;
    endtask

    task automatic t_bimodal();
        do_reset();
        upd(32'h100, 8'h0, 1'b1);
        look(32'h100, 1'b0);
        chk("R3 one taken flips weak", tk_bi, 1);
        for (int i = 0; i < 3; i++) upd(32'h100, 8'h0, 1'b1);
        upd(32'h100, 8'h0, 1'b0);
        look(32'h100, 1'b0);
        chk("R3 strong survives one miss", tk_bi, 1);
        upd(32'h100, 8'h0, 1'b0);
        look(32'h100, 1'b0);
        chk("R3 second miss turns", tk_bi, 0);
        upd(32'h100, 8'h0, 1'b1);
        look(32'h500, 1'b0);
        chk("R4 alias above bit 9", tk_bi, 1);
        look(32'h104, 1'b0);
        chk("R4 neighbour independent", tk_bi, 0);
    endtask

    task automatic t_history();
        logic [7:0] snap;
        do_reset();
        upd(32'h0, 8'h0, 1'b1);
        upd(32'h0, 8'h0, 1'b0);
        upd(32'h0, 8'h0, 1'b1);
        upd(32'h0, 8'h0, 1'b1);
        #1;
        chk("R5 history shift", h_cb, 8'h0B);
        snap = h_cb;
        repeat (3) @(negedge clk);
        #1;
        chk("R5 history holds idle", h_cb, snap);
    endtask

    task automatic t_global_family();
        logic [7:0] pat;
        pat = 8'h5A;
        do_reset();
        upd(32'h200, pat, 1'b1);
        upd(32'h200, pat, 1'b1);
        for (int i = 7; i >= 0; i--) upd(32'h0, 8'hFF, pat[i]);
        #1;
        chk("R5 history loaded", h_cb, 8'h5A);
        look(32'h200, 1'b0);
        chk("R6 global trained pc", tk_gl, 1);
        chk("R7 gshare trained pc", tk_gs, 1);
        chk("R8 gselect trained pc", tk_gx, 1);
        look(32'h37C, 1'b0);
        chk("R6 global other pc same history", tk_gl, 1);
        chk("R7 gshare other pc differs", tk_gs, 0);
        look(32'h204, 1'b0);
        chk("R8 gselect low pc bit differs", tk_gx, 0);
        look(32'h240, 1'b0);
        chk("R8 gselect high pc bits ignored", tk_gx, 1);
    endtask

    task automatic t_snapshot();
        do_reset();
        upd(32'h800, 8'h80, 1'b1);
        upd(32'h40, 8'h00, 1'b1);
        look(32'h4C, 1'b0);
        chk("R9 update used returned snapshot", tk_gs, 1);
        look(32'h40, 1'b0);
        chk("R9 current-history entry untouched", tk_gs, 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        @(negedge clk);
        lk_pc = 32'h300;
        up_valid = 1'b1; up_pc = 32'h300; up_hist = 8'h0; up_taken = 1'b1;
        #1;
        chk("R10 same-cycle sees old", tk_bi, 0);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        chk("R10 update visible next cycle", tk_bi, 1);
        @(negedge clk);
        lk_pc = 32'h304;
        #1;
        chk("R10 back-to-back lookup 1", tk_bi, 0);
        @(negedge clk);
        lk_pc = 32'h300;
        #1;
        chk("R10 back-to-back lookup 2", tk_bi, 1);
    endtask

    task automatic t_combined();
        do_reset();
        upd(32'h100, 8'h00, 1'b1);
        look(32'h100, 1'b0);
        chk("R11 reset chooser picks bimodal", tk_cb, 1);
        upd(32'h100, 8'h01, 1'b0);
        upd(32'h100, 8'h02, 1'b1);
        look(32'h100, 1'b0);
        chk("R11 chooser moved to gshare", tk_cb, 0);
        chk("R11 bimodal side alone says taken", tk_bi, 1);
        upd(32'h100, 8'h05, 1'b1);
        look(32'h100, 1'b0);
        chk("R12 disagreement moves chooser back", tk_cb, 1);
        upd(32'h100, 8'h05, 1'b1);
        look(32'h100, 1'b0);
        chk("R12 agreement leaves chooser", tk_cb, 1);
    endtask

    initial begin
        t_reset_state();
        t_static();
        t_bimodal();
        t_history();
        t_global_family();
        t_snapshot();
        t_same_cycle();
        t_combined();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule